// File: doc/BRIEF.md
# Reset-Gated Memory Chip-Enable

This block sits between a processor's active-low chip-enable and a memory device. It keeps the memory from being written while the processor is held in reset. While the gate is open, the output copies the incoming chip-enable. While the gate is closed, the output is driven to the inactive high level.

A single reset request input carries every reset source, whether a low supply or a watchdog expiry; the block treats them all alike. When the reset request rises in the middle of an access, the block does not cut that access short. It keeps the gate open for a grace window that ends on whichever comes first: the incoming chip-enable going high, or `GRACE_US` microsecond ticks. A free-running one-cycle `us_tick` pulse paces the window. `arst_n` only places the state register in its power-up state.

The controller is a three-state machine:
- `GATE_OPEN`: the output follows the input.
- `GATE_GRACE`: the access in progress is allowed to finish.
- `GATE_CLOSED`: the output is held high.

The transitions are:
- OPEN to GRACE: reset rises while the chip-enable is low.
- OPEN to CLOSED: reset rises while the chip-enable is high.
- GRACE to CLOSED: the chip-enable goes high, or the window expires.
- GRACE to OPEN and CLOSED to OPEN: reset is released.
- After `arst_n`, the machine starts in CLOSED.

Top module: `ce_reset_gate`

## Requirements
- R1: `ce_out_n` is low only while `ce_in_n` is low and the gate is open or in its grace window. While the gate is open, `ce_out_n` equals `ce_in_n` in the same cycle.
- R2: If `sys_rst` rises while `ce_in_n` is low, `ce_out_n` keeps following `ce_in_n` until `ce_in_n` goes high. Once `ce_in_n` is high, the gate closes at the next clock edge.
- R3: Once the grace window has ended, `ce_out_n` stays high for as long as `sys_rst` stays high, whatever `ce_in_n` does.
- R4: After `arst_n` is released with `sys_rst` high (power-up), `ce_out_n` stays high until `sys_rst` is released.
- R5: If `sys_rst` rises while `ce_in_n` is high, the gate closes at that clock edge. There is no grace window, so a later low on `ce_in_n` during the reset is blocked.
- R6: After `sys_rst` falls, `ce_out_n` follows `ce_in_n` from the cycle after the first clock edge that samples `sys_rst` low.
- R7: If `sys_rst` falls during the grace window, the gate goes straight back to open and the access is never interrupted.
- R8: The grace window counts only clock edges on which `us_tick` is high. The gate closes at the clock edge that samples the `GRACE_US`-th tick (default 15) after the window began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-up initialisation of the state register, active low |
| ce_in_n | input | 1 | Chip-enable from the processor, active low |
| sys_rst | input | 1 | Reset request from the supervisor (supply-low or watchdog), active high |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ce_out_n | output | 1 | Gated chip-enable to the memory, active low |

## Verification
The assertions check three things on every cycle:
- a low output always implies a low input;
- a gate that has shut during a reset stays shut until the reset ends;
- one edge after reset is released, the output tracks the input.

A further assertion keeps the grace counter inside its window. The bench scenarios cover the behaviour that spans many cycles:
- the exact tick on which the window expires, and the fact that idle cycles are not counted;
- the difference between reset arriving while an access is active and while the bus is idle;
- the power-up hold;
- an early release of reset during the grace window.

// File: rtl/cegate_pkg.sv
package cegate_pkg;
    typedef enum logic [1:0] {
        GATE_CLOSED = 2'b00,
        GATE_OPEN   = 2'b01,
        GATE_GRACE  = 2'b10
    } gate_state_t;
endpackage

// File: rtl/cegate_grace_timer.sv
module cegate_grace_timer #(
    parameter int GRACE_US = 15
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = (GRACE_US > 1) ? $clog2(GRACE_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(GRACE_US - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run & tick & (cnt == LAST);

    // R8
    grace_count_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cnt <= LAST);
endmodule

// File: rtl/cegate_fsm.sv
module cegate_fsm
    import cegate_pkg::*;
(
    input  logic        clk,
    input  logic        arst_n,
    input  logic        ce_in_n,
    input  logic        sys_rst,
    input  logic        grace_done,
    output gate_state_t state,
    output logic        pass_en,
    output logic        grace_run
);
    gate_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            GATE_OPEN: begin
                if (sys_rst) state_nxt = ce_in_n ? GATE_CLOSED : GATE_GRACE;
            end
            GATE_GRACE: begin
                if (!sys_rst)                  state_nxt = GATE_OPEN;
                else if (ce_in_n || grace_done) state_nxt = GATE_CLOSED;
            end
            GATE_CLOSED: begin
                if (!sys_rst) state_nxt = GATE_OPEN;
            end
            default: state_nxt = GATE_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= GATE_CLOSED;
        else         state <= state_nxt;
    end

    always_comb begin
        pass_en   = 1'b0;
        grace_run = 1'b0;
        unique case (state)
            GATE_OPEN:   pass_en = 1'b1;
            GATE_GRACE: begin
                pass_en   = 1'b1;
                grace_run = 1'b1;
            end
            GATE_CLOSED: pass_en = 1'b0;
            default:     pass_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/ce_reset_gate.sv
module ce_reset_gate
    import cegate_pkg::*;
#(
    parameter int GRACE_US = 15
) (
    input  logic clk,
    input  logic arst_n,
    input  logic ce_in_n,
    input  logic sys_rst,
    input  logic us_tick,
    output logic ce_out_n
);
    gate_state_t state;
    logic        pass_en;
    logic        grace_run;
    logic        grace_done;

    cegate_fsm u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .ce_in_n    (ce_in_n),
        .sys_rst    (sys_rst),
        .grace_done (grace_done),
        .state      (state),
        .pass_en    (pass_en),
        .grace_run  (grace_run)
    );

    cegate_grace_timer #(.GRACE_US(GRACE_US)) u_timer (
        .clk     (clk),
        .arst_n  (arst_n),
        .run     (grace_run),
        .tick    (us_tick),
        .expired (grace_done)
    );

    assign ce_out_n = ce_in_n | ~pass_en;

    // R1
    low_needs_input_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !ce_out_n |-> !ce_in_n);

    // R3
    stays_shut_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (sys_rst && $past(sys_rst) && $past(ce_out_n)) |-> ce_out_n);

    // R6
    follows_after_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(arst_n) && !$past(sys_rst)) |-> (ce_out_n == ce_in_n));
endmodule

// File: tb/tb_ce_reset_gate.sv
module tb_ce_reset_gate;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic ce_in_n = 1'b1;
    logic sys_rst = 1'b1;
    logic us_tick = 1'b0;
    logic ce_out_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    ce_reset_gate #(.GRACE_US(15)) dut (
        .clk      (clk),
        .arst_n   (arst_n),
        .ce_in_n  (ce_in_n),
        .sys_rst  (sys_rst),
        .us_tick  (us_tick),
        .ce_out_n (ce_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(input logic ce, input logic rst, input logic tk,
                        input logic exp, input string tag);
        @(negedge clk);
        ce_in_n = ce;
        sys_rst = rst;
        us_tick = tk;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (ce_out_n !== e) begin
                    fails++;
                    $display("FAIL %s at %0t: ce_out_n=%b expected %b", t, $time, ce_out_n, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state and power-up hold, R4
        step(0, 1, 0, 1, "R4");
        step(0, 1, 0, 1, "R4");
        @(negedge clk);
        arst_n = 1'b1;
        step(0, 1, 0, 1, "R4");
        step(0, 1, 1, 1, "R4");
        step(0, 1, 0, 1, "R4");
        // release: follows one edge later, R6
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, "R6");
        step(1, 0, 0, 1, "R1");
        step(0, 0, 0, 0, "R1");
        // grace ended by the input going high, R2 / R3
        step(0, 1, 0, 0, "R2");
        step(0, 1, 0, 0, "R2");
        step(1, 1, 0, 1, "R2");
        step(0, 1, 0, 1, "R3");
        step(0, 1, 1, 1, "R3");
        step(1, 1, 0, 1, "R3");
        step(0, 1, 0, 1, "R3");
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, "R6");
        // grace ended by tick timeout, R8
        step(0, 1, 0, 0, "R8");
        for (int i = 1; i <= 15; i++) begin
            step(0, 1, 1, 0, "R8");
            if (i == 7) begin
                step(0, 1, 0, 0, "R8");
                step(0, 1, 0, 0, "R8");
            end
        end
        step(0, 1, 0, 1, "R8");
        step(0, 1, 1, 1, "R3");
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, "R1");
        // reset while idle: no grace window, R5
        step(1, 1, 0, 1, "R5");
        step(0, 1, 0, 1, "R5");
        step(0, 1, 0, 1, "R5");
        step(0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, "R6");
        // reset released inside the grace window, R7
        step(0, 1, 0, 0, "R7");
        step(0, 1, 1, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(1, 0, 0, 1, "R1");
        step(0, 0, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule